// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Programmable Frame Format

This block turns bytes into asynchronous serial frames on a single output line. A seven-bit line-control input picks the frame layout:
- 5 to 8 data bits;
- one stop bit, or a longer stop period;
- no parity, odd, even, or a parity bit held at a fixed value;
- a break override that pulls the line low.

The bit timing comes from an external baud divider as a one-cycle tick at sixteen times the bit rate.

Bytes arrive over a valid/ready handshake into a one-byte holding stage. The frame sequencer takes the byte from there when it is idle. While one frame is on the line, a second byte can wait in the holding stage. Two status outputs show whether a frame is in progress and whether the transmitter has drained completely.

Top module: `frame_tx`

## Requirements
- R1: After reset the line is high, `tx_busy` is 0, `tx_empty` is 1 and `tx_ready` is 1. With `line_ctl` all zero, a frame has 5 data bits, no parity and one stop bit.
- R2: A frame is one start bit at 0, then the data bits least significant first, each bit 16 ticks long. The count of data bits comes from `line_ctl[1:0]`: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Unused upper data bits are not sent.
- R3: With `line_ctl[3]` = 0 no parity bit is sent, whatever `line_ctl[5:4]` hold. The stop period follows the last data bit directly.
- R4: With `line_ctl[3]` = 1 and `line_ctl[5]` = 0, a parity bit follows the data bits. `line_ctl[4]` = 0 makes the number of ones in data plus parity odd. `line_ctl[4]` = 1 makes it even.
- R5: With `line_ctl[3]` = 1 and `line_ctl[5]` = 1, the parity bit is sent as 1 when `line_ctl[4]` = 0 and as 0 when `line_ctl[4]` = 1, independent of the data.
- R6: The stop period is high and lasts 16 ticks when `line_ctl[2]` = 0. When `line_ctl[2]` = 1 it lasts 24 ticks for 5-bit words and 32 ticks for 6 to 8 bit words. `tx_busy` is high from the cycle after the byte is taken until the stop period ends.
- R7: While `line_ctl[6]` = 1, `tx_line` is 0 in the same cycle, whether the sequencer is idle or sending.
- R8: When `line_ctl[6]` falls while a frame is in progress, that frame is dropped. On the next clock edge `tx_busy` goes 0 and the line returns high. Later frames are sent normally.
- R9: The word length, stop and parity-enable settings are captured when a frame starts. A change to those bits during the frame does not affect it.
- R10: `tx_ready` is 1 exactly when the holding stage is empty. An accepted byte is kept unchanged until the sequencer takes it. `tx_empty` is 1 only when nothing is held and no frame is in progress. A second byte accepted during a frame is sent after it.
- R11: The sequencer moves only on cycles where `baud_tick` is 1. If ticks stop, the current bit is held. A tick on every other clock doubles every bit's length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| line_ctl | input | 7 | Frame format: [1:0] word length, [2] long stop, [3] parity on, [4] even or fixed-0, [5] fixed parity, [6] break |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Holding stage can accept a byte |
| tx_line | output | 1 | Serial output, idles high |
| tx_busy | output | 1 | A frame is in progress |
| tx_empty | output | 1 | Nothing held and no frame in progress |

## Verification
Frames are sent in every word length, and the data values are chosen so that word length, bit order and truncation of unused upper bits each show up as a different waveform. The data bytes for odd, even and fixed parity are picked so that every parity mode gives a different bit from the others. Each parity bit is placed in a known slot, so a missing or extra parity bit is caught as a frame-length error. Separate sequences cover the following:
- changing the format in the middle of a frame;
- queuing a second byte behind a running frame;
- raising break while idle and while sending, and dropping it mid-frame;
- slowing the tick or stopping it, to tell a tick-driven sequencer from one that counts clocks.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;

  localparam int unsigned WORD_MAX = 8;

  // Line-control fields below the break bit; bit order follows the control input.
  typedef struct packed {
    logic       stick;
    logic       even;
    logic       par_en;
    logic       stop_long;
    logic [1:0] wsel;
  } fmt_t;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_DATA  = 3'd2,
    S_PAR   = 3'd3,
    S_STOP  = 3'd4
  } seq_state_t;

  // Number of data bits for a word-length code.
  function automatic int unsigned word_bits(logic [1:0] wsel);
    return 32'd5 + 32'(wsel);
  endfunction

  // Parity bit to send for a byte under a given format.
  function automatic logic parity_of(logic [WORD_MAX-1:0] d, fmt_t f);
    logic [WORD_MAX-1:0] mask;
    logic                ones_odd;
    mask     = 8'hFF >> (2'd3 - f.wsel);
    ones_odd = ^(d & mask);
    if (f.stick) return ~f.even;
    return f.even ? ones_odd : ~ones_odd;
  endfunction

  // Stop period length in ticks for the latched stop and word settings.
  function automatic int unsigned stop_ticks(logic stop_long, logic [1:0] wsel,
                                             int unsigned ovs);
    if (!stop_long)     return ovs;
    if (wsel == 2'b00)  return ovs + ovs / 2;
    return 2 * ovs;
  endfunction

endpackage

// File: rtl/frame_tx_hold.sv
module frame_tx_hold #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  input  logic         take,
  output logic         held_full,
  output logic [W-1:0] held_data
);

  logic accept;

  assign in_ready = ~held_full;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_full <= 1'b0;
      held_data <= '0;
    end else if (accept) begin
      held_full <= 1'b1;
      held_data <= in_data;
    end else if (take) begin
      held_full <= 1'b0;
    end
  end

  // R10: a held byte stays put until the sequencer takes it
  a_r10_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (held_full && !take) |=> (held_full && $stable(held_data)));

  // R10: a take always frees the stage
  a_r10_take_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (held_full && take) |=> !held_full);

endmodule

// File: rtl/frame_tx_seq.sv
module frame_tx_seq
  import frame_tx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  fmt_t                cur_fmt,
  input  logic                brk,
  input  logic                pend_full,
  input  logic [WORD_MAX-1:0] pend_data,
  output logic                take,
  output logic                ser_bit,
  output logic                busy
);

  localparam int unsigned CW = $clog2(2 * OVS);
  localparam int unsigned IW = $clog2(WORD_MAX);

  seq_state_t          state_q;
  logic [CW-1:0]       cnt_q;
  logic [IW-1:0]       idx_q;
  logic [WORD_MAX-1:0] sh_q;
  logic                par_q;
  logic                brk_q;
  logic [1:0]          wsel_q;
  logic                stop_long_q;
  logic                par_en_q;

  // named events for the assertions
  logic [CW-1:0] tick_last;
  logic [IW-1:0] idx_last;
  logic          abort;
  logic          bit_end;
  logic          frame_start;

  always_comb begin
    if (state_q == S_STOP) tick_last = CW'(stop_ticks(stop_long_q, wsel_q, OVS) - 1);
    else                   tick_last = CW'(OVS - 1);
  end

  assign idx_last    = IW'(word_bits(wsel_q) - 1);
  assign abort       = brk_q & ~brk & (state_q != S_IDLE);
  assign bit_end     = tick & (cnt_q == tick_last) & (state_q != S_IDLE);
  assign frame_start = (state_q == S_IDLE) & pend_full;
  assign take        = frame_start;
  assign busy        = (state_q != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      cnt_q       <= '0;
      idx_q       <= '0;
      sh_q        <= '0;
      par_q       <= 1'b0;
      brk_q       <= 1'b0;
      wsel_q      <= 2'b00;
      stop_long_q <= 1'b0;
      par_en_q    <= 1'b0;
    end else begin
      brk_q <= brk;
      if (abort) begin
        state_q <= S_IDLE;
        cnt_q   <= '0;
      end else if (frame_start) begin
        state_q     <= S_START;
        cnt_q       <= '0;
        idx_q       <= '0;
        sh_q        <= pend_data;
        par_q       <= parity_of(pend_data, cur_fmt);
        wsel_q      <= cur_fmt.wsel;
        stop_long_q <= cur_fmt.stop_long;
        par_en_q    <= cur_fmt.par_en;
      end else if (busy && tick) begin
        if (!bit_end) begin
          cnt_q <= cnt_q + 1'b1;
        end else begin
          cnt_q <= '0;
          case (state_q)
            S_START: state_q <= S_DATA;
            S_DATA: begin
              sh_q  <= sh_q >> 1;
              idx_q <= idx_q + 1'b1;
              if (idx_q == idx_last) state_q <= par_en_q ? S_PAR : S_STOP;
            end
            S_PAR:   state_q <= S_STOP;
            default: state_q <= S_IDLE;
          endcase
        end
      end
    end
  end

  always_comb begin
    case (state_q)
      S_START: ser_bit = 1'b0;
      S_DATA:  ser_bit = sh_q[0];
      S_PAR:   ser_bit = par_q;
      default: ser_bit = 1'b1;
    endcase
  end

  // R8: dropping break mid-frame returns the sequencer to idle
  a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(brk) && state_q != S_IDLE) |=> (state_q == S_IDLE));

  // R11: without a tick the sequencer does not move
  a_r11_wait_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && state_q != S_IDLE && !abort) |=> ($stable(cnt_q) && $stable(state_q)));

  // R9: latched format is frozen during a frame
  a_r9_fmt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE) |=> ($stable(wsel_q) && $stable(stop_long_q) && $stable(par_en_q)));

  // R6: stop period never runs past its length
  a_r6_stop_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_STOP) |-> (cnt_q <= tick_last));

  // R2: data index stays within the word
  a_r2_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DATA) |-> (idx_q <= idx_last));

endmodule

// File: rtl/frame_tx_line.sv
module frame_tx_line (
  input  logic clk,
  input  logic rst_n,
  input  logic brk,
  input  logic ser_bit,
  output logic tx_line
);

  assign tx_line = brk ? 1'b0 : ser_bit;

  // R7: break holds the line low
  a_r7_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !tx_line);

endmodule

// File: rtl/frame_tx.sv
module frame_tx
  import frame_tx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                baud_tick,
  input  logic [6:0]          line_ctl,
  input  logic [WORD_MAX-1:0] tx_data,
  input  logic                tx_valid,
  output logic                tx_ready,
  output logic                tx_line,
  output logic                tx_busy,
  output logic                tx_empty
);

  fmt_t                cur_fmt;
  logic                brk;
  logic                held_full;
  logic [WORD_MAX-1:0] held_data;
  logic                take;
  logic                ser_bit;

  assign cur_fmt  = fmt_t'(line_ctl[5:0]);
  assign brk      = line_ctl[6];
  assign tx_empty = ~held_full & ~tx_busy;

  frame_tx_hold #(.W(WORD_MAX)) hold_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (tx_valid),
    .in_data   (tx_data),
    .in_ready  (tx_ready),
    .take      (take),
    .held_full (held_full),
    .held_data (held_data)
  );

  frame_tx_seq #(.OVS(OVS)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (baud_tick),
    .cur_fmt   (cur_fmt),
    .brk       (brk),
    .pend_full (held_full),
    .pend_data (held_data),
    .take      (take),
    .ser_bit   (ser_bit),
    .busy      (tx_busy)
  );

  frame_tx_line line_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .brk     (brk),
    .ser_bit (ser_bit),
    .tx_line (tx_line)
  );

  // R10: a held byte is taken only by an idle sequencer
  a_r10_take_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (held_full && !tx_busy) |=> (tx_busy || !held_full || $past(line_ctl[6])));

endmodule

// File: tb/frame_tx_tb_top.sv
module frame_tx_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic [6:0] line_ctl = 7'h00;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready, tx_line, tx_busy, tx_empty;

  int checks = 0;
  int errors = 0;
  int tick_div = 1;
  int phase = 0;
  logic rec [0:1023];

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (tick_div == 0) begin
      baud_tick <= 1'b0;
    end else if (phase >= tick_div - 1) begin
      baud_tick <= 1'b1;
      phase <= 0;
    end else begin
      baud_tick <= 1'b0;
      phase <= phase + 1;
    end
  end

  frame_tx dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .line_ctl(line_ctl),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_line(tx_line), .tx_busy(tx_busy), .tx_empty(tx_empty)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    tx_data  = d;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // Records the line from the first low sample until busy drops.
  task automatic capture(input logic [6:0] lcr_mid, output int len);
    int guard = 0;
    @(negedge clk);
    while (tx_line !== 1'b0 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    line_ctl = lcr_mid;
    len = 0;
    while (tx_busy === 1'b1 && len < 1000) begin
      rec[len] = tx_line;
      len++;
      @(negedge clk);
    end
  endtask

  task automatic verify(input logic [6:0] lcr, input logic [7:0] d, input int div,
                        input int len, input string req);
    int n, p, ones, st, total, e;
    logic exp_bits [0:10];
    n = 5 + int'(lcr[1:0]);
    p = lcr[3] ? 1 : 0;
    ones = 0;
    exp_bits[0] = 1'b0;
    for (int i = 0; i < n; i++) begin
      exp_bits[1+i] = d[i];
      if (d[i]) ones++;
    end
    if (p == 1) begin
      if (lcr[5])      exp_bits[1+n] = ~lcr[4];
      else if (lcr[4]) exp_bits[1+n] = (ones % 2 == 1);
      else             exp_bits[1+n] = (ones % 2 == 0);
    end
    st = !lcr[2] ? 16 : ((n == 5) ? 24 : 32);
    total = 16 * (1 + n + p) + st;
    for (int j = 0; j < 1 + n + p; j++) begin
      e = (16 * j + 8) * div;
      chk(e < len && rec[e] === exp_bits[j], {req, " frame bit"},
          (e < len) ? int'(rec[e]) : -1, int'(exp_bits[j]));
    end
    e = (16 * (1 + n + p) + st - 2) * div;
    chk(e < len && rec[e] === 1'b1, {req, " stop level"}, (e < len) ? int'(rec[e]) : -1, 1);
    chk(len >= total * div - (div - 1) && len <= total * div + (div - 1),
        {req, " frame length"}, len, total * div);
  endtask

  task automatic check_frame(input logic [6:0] lcr, input logic [7:0] d, input string req);
    int len;
    line_ctl = lcr;
    send(d);
    capture(lcr, len);
    verify(lcr, d, tick_div, len, req);
  endtask

  task automatic t_reset();
    #1;
    chk(tx_line === 1'b1, "R1 line after reset", int'(tx_line), 1);
    chk(tx_busy === 1'b0, "R1 busy after reset", int'(tx_busy), 0);
    chk(tx_empty === 1'b1, "R1 empty after reset", int'(tx_empty), 1);
    chk(tx_ready === 1'b1, "R1 ready after reset", int'(tx_ready), 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_frame(7'h00, 8'hF3, "R1 default 5N1");
  endtask

  task automatic t_words();
    check_frame(7'h03, 8'hA5, "R2 8-bit");
    check_frame(7'h01, 8'hEC, "R2 6-bit");
    check_frame(7'h02, 8'hD5, "R2 7-bit");
    check_frame(7'h00, 8'h2E, "R2 5-bit");
  endtask

  task automatic t_parity();
    check_frame(7'h13, 8'h37, "R3 parity off, even bit set");
    check_frame(7'h33, 8'h01, "R3 parity off, stick set");
    check_frame(7'h0B, 8'h37, "R4 odd 8-bit");
    check_frame(7'h1B, 8'h37, "R4 even 8-bit");
    check_frame(7'h0A, 8'h80, "R4 odd 7-bit ignores bit7");
    check_frame(7'h18, 8'hE3, "R4 even 5-bit");
    check_frame(7'h2B, 8'h00, "R5 fixed one");
    check_frame(7'h3B, 8'hFF, "R5 fixed zero");
    check_frame(7'h28, 8'h1F, "R5 fixed one 5-bit");
  endtask

  task automatic t_stop();
    check_frame(7'h04, 8'h15, "R6 5-bit long stop");
    check_frame(7'h07, 8'h69, "R6 8-bit two stop");
    check_frame(7'h05, 8'h2A, "R6 6-bit two stop");
    check_frame(7'h0C, 8'h0F, "R6 5-bit parity long stop");
  endtask

  task automatic t_fmt_latch();
    int len;
    line_ctl = 7'h03;
    send(8'hC3);
    capture(7'h04, len);
    verify(7'h03, 8'hC3, 1, len, "R9 format change mid-frame");
    check_frame(7'h04, 8'h19, "R9 new format next frame");
  endtask

  task automatic t_queue();
    int len;
    int guard = 0;
    line_ctl = 7'h03;
    @(negedge clk);
    tx_data  = 8'h5A;
    tx_valid = 1'b1;
    @(negedge clk);
    chk(tx_ready === 1'b0, "R10 ready low when held", int'(tx_ready), 0);
    chk(tx_empty === 1'b0, "R10 not empty when held", int'(tx_empty), 0);
    tx_data = 8'h96;
    @(negedge clk);
    chk(tx_busy === 1'b1, "R10 frame started", int'(tx_busy), 1);
    chk(tx_ready === 1'b1, "R10 ready after take", int'(tx_ready), 1);
    @(negedge clk);
    tx_valid = 1'b0;
    tx_data  = 8'h00;
    chk(tx_ready === 1'b0, "R10 second byte held", int'(tx_ready), 0);
    chk(tx_empty === 1'b0, "R10 busy and held not empty", int'(tx_empty), 0);
    while (tx_busy === 1'b1 && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    capture(7'h03, len);
    verify(7'h03, 8'h96, 1, len, "R10 queued byte sent");
    @(negedge clk);
    chk(tx_empty === 1'b1, "R10 empty after drain", int'(tx_empty), 1);
  endtask

  task automatic t_break();
    int bad = 0;
    @(negedge clk);
    line_ctl = 7'h43;
    #1;
    chk(tx_line === 1'b0, "R7 break at idle", int'(tx_line), 0);
    chk(tx_busy === 1'b0, "R7 break idle not busy", int'(tx_busy), 0);
    send(8'hFF);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tx_line !== 1'b0) bad++;
    end
    chk(bad == 0, "R7 line low during frame", bad, 0);
    chk(tx_busy === 1'b1, "R7 frame runs under break", int'(tx_busy), 1);
    line_ctl = 7'h03;
    @(negedge clk);
    chk(tx_busy === 1'b0, "R8 frame dropped", int'(tx_busy), 0);
    chk(tx_line === 1'b1, "R8 line idle high", int'(tx_line), 1);
    chk(tx_empty === 1'b1, "R8 empty after drop", int'(tx_empty), 1);
    check_frame(7'h03, 8'h3C, "R8 frame after break");
  endtask

  task automatic t_tick();
    int guard = 0;
    tick_div = 2;
    check_frame(7'h03, 8'hB4, "R11 half-rate tick");
    tick_div = 0;
    line_ctl = 7'h03;
    send(8'h5A);
    repeat (60) @(negedge clk);
    chk(tx_busy === 1'b1, "R11 stalled busy", int'(tx_busy), 1);
    chk(tx_line === 1'b0, "R11 stalled in start", int'(tx_line), 0);
    tick_div = 1;
    while (tx_busy === 1'b1 && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    chk(guard >= 150 && guard <= 162, "R11 resumes after stall", guard, 160);
  endtask

  initial begin
    t_reset();
    t_words();
    t_parity();
    t_stop();
    t_fmt_latch();
    t_queue();
    t_break();
    t_tick();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual=hung expected=done");
    summary();
    $finish;
  end

endmodule